// File: doc/BRIEF.md
# PWM-Synchronized Simultaneous Sample Sequencer

This block governs a group of per-channel sample-and-hold stages that all feed one shared converter core. It follows a PWM carrier counter. When the counter reaches a chosen position, the block waits for a programmable number of clocks. It then issues one hold command, so every channel freezes its input on the same clock edge. After that it steps the shared core through the held channels one at a time, in ascending channel order.

Each conversion result is stamped with its channel number and with a set sequence number. The results are gathered into one flat sample-set vector, and a one-cycle valid pulse marks the set as complete. The trigger point is either the midpoint of the carrier period or an explicit position. Capture runs in one of two modes. In periodic mode a set is taken on every Nth carrier match. In one-shot mode a single request arms the block for exactly one set.

Top module: `pwm_sync_sample_seq`

## Requirements
- R1: A capture begins with `hold_strobe` high for exactly one cycle. In the next cycle `sh_hold` is high for all channels together, and `core_start` pulses with `mux_sel` = 0.
- R2: Conversions run in ascending channel order 0..NUM_CH-1. Each later `core_start` pulse comes in the cycle after the `core_done` of the previous channel, with `mux_sel` one higher than before. `core_start` is only issued while `sh_hold` is high.
- R3: `sh_hold` stays high from the cycle after the strobe until the final channel's `core_done` has been taken. It falls in the same cycle that `set_valid` rises, so it is high for NUM_CH*(L+1) cycles when the core answers L cycles after each start.
- R4: `set_valid` is a one-cycle pulse. Slot i of `set_data` is bits [i*RES_W +: RES_W] with RES_W = SEQ_W+CH_W+DATA_W. The slot holds {sequence number (top SEQ_W bits), channel tag i (next CH_W bits), core data (low DATA_W bits)}. The sequence number starts at 0 after reset, rises by one per completed set, and wraps modulo 2^SEQ_W.
- R5: The trigger position is `carrier_period`>>1 when `trig_at_mid`=1, and `trig_pos` otherwise. A carrier match is the first cycle in which `carrier_cnt` equals that position.
- R6: A qualifying match seen in cycle k produces `hold_strobe` in cycle k+1+`hold_delay`.
- R7: With `periodic_en`=0, no capture happens until `oneshot_req` is pulsed. A pulse arms the block, and it then captures exactly one set at the next carrier match before disarming.
- R8: With `periodic_en`=1, a capture happens on every (`period_div`+1)th carrier match. Consecutive strobes are therefore (`period_div`+1)*(`carrier_period`+1) cycles apart for a carrier that counts 0..`carrier_period` once per clock.
- R9: A qualifying trigger that arrives while a capture is still in its delay or conversion phase is dropped and sets `overrun`. `overrun` stays high until reset, and it is never set when no trigger was dropped.
- R10: From `hold_strobe` to `set_valid` takes exactly NUM_CH*(L+1)+1 cycles. The set rate is therefore the per-conversion rate divided by NUM_CH.
- R11: After reset, `hold_strobe`, `sh_hold`, `core_start`, `set_valid`, `overrun` and `mux_sel` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| carrier_cnt | input | CNT_W | Current PWM carrier counter value |
| carrier_period | input | CNT_W | Carrier terminal count |
| trig_pos | input | CNT_W | Explicit trigger position |
| trig_at_mid | input | 1 | 1 selects the carrier midpoint as trigger position |
| hold_delay | input | DLY_W | Clocks between match and hold strobe |
| periodic_en | input | 1 | 1 periodic mode, 0 one-shot mode |
| period_div | input | DIV_W | Capture every period_div+1 matches |
| oneshot_req | input | 1 | Arms one capture in one-shot mode |
| core_done | input | 1 | Shared core finished a conversion |
| core_data | input | DATA_W | Shared core result |
| hold_strobe | output | 1 | One-cycle common hold command |
| sh_hold | output | 1 | Hold level for all sample-and-hold stages |
| mux_sel | output | CH_W | Channel routed to the core |
| core_start | output | 1 | Start pulse to the core |
| set_valid | output | 1 | Sample set complete pulse |
| set_data | output | NUM_CH*RES_W | Packed tagged results |
| overrun | output | 1 | Sticky dropped-trigger flag |

## Verification
Periodic capture is swept over both trigger-position choices, two carrier periods, four delays and three dividers. The strobe-to-match distance separates errors in position from errors in delay, and the strobe spacing exposes divider faults. One-shot runs check that nothing happens before arming and that each request yields exactly one set. A short carrier with conversions longer than a period forces dropped triggers; a fixed spacing of three periods and the sticky flag distinguish correct drop-on-busy from queuing or restarting. Every completed set is compared slot by slot against the data the bench's core model returned, which catches ordering, tagging and sequence-number faults.

// File: rtl/sseq_pkg.sv
package sseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_CONV  = 2'd2
  } sseq_state_e;

  // Carrier position at which the capture reference point lies.
  function automatic int unsigned trig_point(input logic at_mid,
                                             input int unsigned pos,
                                             input int unsigned period);
    return at_mid ? (period >> 1) : pos;
  endfunction

  // Next value of a modulo divider counter that wraps at div_val.
  function automatic int unsigned div_next(input int unsigned cnt,
                                           input int unsigned div_val);
    return (cnt >= div_val) ? 0 : cnt + 1;
  endfunction

endpackage

// File: rtl/sseq_trigger.sv
module sseq_trigger #(
  parameter int CNT_W = 8,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] carrier_cnt,
  input  logic [CNT_W-1:0] carrier_period,
  input  logic [CNT_W-1:0] trig_pos,
  input  logic             trig_at_mid,
  input  logic             periodic_en,
  input  logic [DIV_W-1:0] period_div,
  input  logic             oneshot_req,
  output logic             trig_evt
);
  import sseq_pkg::*;

  logic [CNT_W-1:0] point;
  logic             hit, hit_q, match_evt;
  logic [DIV_W-1:0] div_cnt;
  logic             div_done, armed;

  assign point     = CNT_W'(trig_point(trig_at_mid, 32'(trig_pos), 32'(carrier_period)));
  assign hit       = (carrier_cnt == point);
  assign match_evt = hit & ~hit_q;
  assign div_done  = (div_cnt == period_div);
  assign trig_evt  = match_evt & (periodic_en ? div_done : armed);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q   <= 1'b0;
      div_cnt <= '0;
      armed   <= 1'b0;
    end else begin
      hit_q <= hit;
      if (!periodic_en)
        div_cnt <= '0;
      else if (match_evt)
        div_cnt <= DIV_W'(div_next(32'(div_cnt), 32'(period_div)));
      if (oneshot_req)
        armed <= 1'b1;
      else if (trig_evt && !periodic_en)
        armed <= 1'b0;
    end
  end

endmodule

// File: rtl/sseq_ctrl.sv
module sseq_ctrl #(
  parameter int NUM_CH = 4,
  parameter int DLY_W  = 8,
  parameter int CH_W   = 2,
  parameter int SEQ_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_evt,
  input  logic [DLY_W-1:0] hold_delay,
  input  logic             core_done,
  output logic             hold_strobe,
  output logic             sh_hold,
  output logic             core_start,
  output logic [CH_W-1:0]  ch_idx,
  output logic             store_en,
  output logic             conv_last,
  output logic             busy,
  output logic             set_valid,
  output logic [SEQ_W-1:0] seq,
  output logic             overrun
);
  import sseq_pkg::*;

  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  sseq_state_e      state;
  logic [DLY_W-1:0] dly_cnt;
  logic             last_ch;

  assign busy        = (state != ST_IDLE);
  assign hold_strobe = (state == ST_DELAY) && (dly_cnt == '0);
  assign sh_hold     = (state == ST_CONV);
  assign store_en    = sh_hold && core_done;
  assign last_ch     = (ch_idx == LAST_CH);
  assign conv_last   = store_en && last_ch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      dly_cnt    <= '0;
      ch_idx     <= '0;
      core_start <= 1'b0;
      set_valid  <= 1'b0;
      seq        <= '0;
      overrun    <= 1'b0;
    end else begin
      core_start <= 1'b0;
      set_valid  <= 1'b0;
      if (trig_evt && busy)
        overrun <= 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (trig_evt) begin
            dly_cnt <= hold_delay;
            state   <= ST_DELAY;
          end
        end
        ST_DELAY: begin
          if (dly_cnt == '0) begin
            state      <= ST_CONV;
            ch_idx     <= '0;
            core_start <= 1'b1;
          end else begin
            dly_cnt <= dly_cnt - 1'b1;
          end
        end
        ST_CONV: begin
          if (store_en) begin
            if (last_ch) begin
              state     <= ST_IDLE;
              ch_idx    <= '0;
              set_valid <= 1'b1;
              seq       <= seq + 1'b1;
            end else begin
              ch_idx     <= ch_idx + 1'b1;
              core_start <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sseq_collect.sv
module sseq_collect #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2,
  parameter int DATA_W = 12,
  parameter int SEQ_W  = 4,
  localparam int RES_W = SEQ_W + CH_W + DATA_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    store_en,
  input  logic [CH_W-1:0]         ch_idx,
  input  logic [SEQ_W-1:0]        seq,
  input  logic [DATA_W-1:0]       core_data,
  output logic [NUM_CH*RES_W-1:0] set_data
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    logic [RES_W-1:0] word;
    always_ff @(posedge clk) begin
      if (!rst_n)
        word <= '0;
      else if (store_en && (ch_idx == CH_W'(g)))
        word <= {seq, CH_W'(g), core_data};
    end
    assign set_data[g*RES_W +: RES_W] = word;
  end

endmodule

// File: rtl/pwm_sync_sample_seq.sv
module pwm_sync_sample_seq #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 8,
  parameter int DLY_W  = 8,
  parameter int DATA_W = 12,
  parameter int SEQ_W  = 4,
  parameter int DIV_W  = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int RES_W = SEQ_W + CH_W + DATA_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CNT_W-1:0]        carrier_cnt,
  input  logic [CNT_W-1:0]        carrier_period,
  input  logic [CNT_W-1:0]        trig_pos,
  input  logic                    trig_at_mid,
  input  logic [DLY_W-1:0]        hold_delay,
  input  logic                    periodic_en,
  input  logic [DIV_W-1:0]        period_div,
  input  logic                    oneshot_req,
  input  logic                    core_done,
  input  logic [DATA_W-1:0]       core_data,
  output logic                    hold_strobe,
  output logic                    sh_hold,
  output logic [CH_W-1:0]         mux_sel,
  output logic                    core_start,
  output logic                    set_valid,
  output logic [NUM_CH*RES_W-1:0] set_data,
  output logic                    overrun
);

  // Internal events brought out by name for the checker.
  logic             trig_evt;
  logic             store_en;
  logic             conv_last;
  logic             busy;
  logic [SEQ_W-1:0] seq;

  sseq_trigger #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_trigger (
    .clk(clk), .rst_n(rst_n),
    .carrier_cnt(carrier_cnt), .carrier_period(carrier_period),
    .trig_pos(trig_pos), .trig_at_mid(trig_at_mid),
    .periodic_en(periodic_en), .period_div(period_div),
    .oneshot_req(oneshot_req), .trig_evt(trig_evt)
  );

  sseq_ctrl #(.NUM_CH(NUM_CH), .DLY_W(DLY_W), .CH_W(CH_W), .SEQ_W(SEQ_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .trig_evt(trig_evt), .hold_delay(hold_delay), .core_done(core_done),
    .hold_strobe(hold_strobe), .sh_hold(sh_hold), .core_start(core_start),
    .ch_idx(mux_sel), .store_en(store_en), .conv_last(conv_last), .busy(busy),
    .set_valid(set_valid), .seq(seq), .overrun(overrun)
  );

  sseq_collect #(.NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W), .SEQ_W(SEQ_W)) u_collect (
    .clk(clk), .rst_n(rst_n),
    .store_en(store_en), .ch_idx(mux_sel), .seq(seq),
    .core_data(core_data), .set_data(set_data)
  );

endmodule

// File: rtl/sseq_checker.sv
module sseq_checker #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hold_strobe,
  input logic            sh_hold,
  input logic            core_start,
  input logic [CH_W-1:0] mux_sel,
  input logic            set_valid,
  input logic            overrun,
  input logic            trig_evt,
  input logic            busy,
  input logic            conv_last
);

  p_strobe_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hold_strobe |=> !hold_strobe);

  p_hold_after_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hold_strobe |=> (sh_hold && core_start && (mux_sel == '0)));

  p_start_in_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> sh_hold);

  p_ascending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (core_start && !$past(hold_strobe)) |-> (mux_sel == $past(mux_sel) + 1'b1));

  p_release_with_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sh_hold) |-> set_valid);

  p_valid_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid |-> $past(conv_last));

  p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid |=> !set_valid);

  p_drop_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_evt && busy) |=> overrun);

  p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

endmodule

bind pwm_sync_sample_seq sseq_checker #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_sseq_chk (
  .clk(clk), .rst_n(rst_n), .hold_strobe(hold_strobe), .sh_hold(sh_hold),
  .core_start(core_start), .mux_sel(mux_sel), .set_valid(set_valid),
  .overrun(overrun), .trig_evt(trig_evt), .busy(busy), .conv_last(conv_last)
);

// File: tb/pwm_sync_sample_seq_test.sv
module pwm_sync_sample_seq_test;
  localparam int NUM_CH = 4, CNT_W = 8, DLY_W = 8, DATA_W = 12, SEQ_W = 4, DIV_W = 4;
  localparam int CH_W = 2, RES_W = SEQ_W + CH_W + DATA_W, LAT = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [CNT_W-1:0] carrier_cnt = '0;
  logic oneshot_req = 1'b0, core_done = 1'b0;
  logic [DATA_W-1:0] core_data = '0;
  logic hold_strobe, sh_hold, core_start, set_valid, overrun;
  logic [CH_W-1:0] mux_sel;
  logic [NUM_CH*RES_W-1:0] set_data;

  int per = 19, tpos = 7, dly = 0, dv = 0, exp_spacing = 0;
  bit mid = 0, per_en = 0;

  pwm_sync_sample_seq #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .DLY_W(DLY_W), .DATA_W(DATA_W),
                        .SEQ_W(SEQ_W), .DIV_W(DIV_W)) uut (
    .clk(clk), .rst_n(rst_n), .carrier_cnt(carrier_cnt),
    .carrier_period(CNT_W'(per)), .trig_pos(CNT_W'(tpos)), .trig_at_mid(mid),
    .hold_delay(DLY_W'(dly)), .periodic_en(per_en), .period_div(DIV_W'(dv)),
    .oneshot_req(oneshot_req), .core_done(core_done), .core_data(core_data),
    .hold_strobe(hold_strobe), .sh_hold(sh_hold), .mux_sel(mux_sel),
    .core_start(core_start), .set_valid(set_valid), .set_data(set_data), .overrun(overrun)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor, carrier model and shared-core model, all at the falling edge.
  int car = 0, last_match = -1, last_strobe = -1, strobes = 0, sets = 0;
  int exp_ch = 0, exp_seq = 0, hold_cnt = 0, ccnt = 0, conv_num = 0;
  bit cbusy = 0;
  logic [DATA_W-1:0] got [NUM_CH];
  logic [DATA_W-1:0] dval;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sh_hold) hold_cnt++;
      if (hold_strobe) begin
        strobes++;
        if (last_match >= 0)
          chk(cyc - last_match == dly + 1, "R5 R6", "match to strobe", cyc - last_match, dly + 1);
        if (exp_spacing > 0 && last_strobe >= 0)
          chk(cyc - last_strobe == exp_spacing, "R8", "strobe spacing", cyc - last_strobe, exp_spacing);
        last_strobe = cyc;
        hold_cnt = 0;
        exp_ch = 0;
      end
      if (core_start) begin
        chk(sh_hold, "R1", "hold during start", sh_hold, 1);
        chk(mux_sel == CH_W'(exp_ch), "R2", "channel order", mux_sel, exp_ch);
        exp_ch++;
      end
      if (set_valid) begin
        chk(cyc - last_strobe == NUM_CH*(LAT+1) + 1, "R10", "strobe to valid",
            cyc - last_strobe, NUM_CH*(LAT+1) + 1);
        chk(!sh_hold && hold_cnt == NUM_CH*(LAT+1), "R3", "hold cycles", hold_cnt, NUM_CH*(LAT+1));
        for (int i = 0; i < NUM_CH; i++) begin
          logic [RES_W-1:0] w, e;
          w = set_data[i*RES_W +: RES_W];
          e = {SEQ_W'(exp_seq), CH_W'(i), got[i]};
          chk(w == e, "R4", "slot word", w, e);
        end
        exp_seq = (exp_seq + 1) % (1 << SEQ_W);
        sets++;
      end
      // shared core: answers LAT cycles after each start
      core_done = 1'b0;
      if (cbusy) begin
        if (ccnt == 1) begin
          core_done = 1'b1;
          core_data = dval;
          cbusy = 0;
        end else ccnt--;
      end
      if (core_start) begin
        cbusy = 1;
        ccnt = LAT;
        conv_num++;
        dval = DATA_W'(conv_num * 37 + int'(mux_sel) * 5);
        got[mux_sel] = dval;
      end
      // carrier counts 0..per, one step per clock
      car = (car >= per) ? 0 : car + 1;
      carrier_cnt = CNT_W'(car);
      if (car == (mid ? per / 2 : tpos)) last_match = cyc;
    end
  end

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic run_periodic(input bit m, input int d, input int div_v, input int p);
    int base, guard;
    per_en = 0;
    settle(60);
    mid = m; dly = d; dv = div_v; per = p;
    exp_spacing = (div_v + 1) * (p + 1);
    last_strobe = -1; last_match = -1;
    base = strobes;
    per_en = 1;
    guard = 0;
    while (strobes - base < 4 && guard < 2000) begin
      settle(1);
      guard++;
    end
    chk(strobes - base >= 4, "R8", "periodic strobes", strobes - base, 4);
  endtask

  initial begin
    int base_s, base_v;
    settle(5);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!hold_strobe && !sh_hold && !core_start && !set_valid && !overrun && mux_sel == '0,
        "R11", "reset outputs", {hold_strobe, sh_hold, core_start, set_valid, overrun, mux_sel}, 0);
    settle(1);

    // R5 R6 R8 R10 sweep of position, delay, divider and period
    for (int pi = 0; pi < 2; pi++)
      for (int m = 0; m < 2; m++)
        for (int d = 0; d < 4; d++)
          for (int v = 0; v < 3; v++)
            run_periodic(bit'(m), d, v, pi ? 25 : 19);

    // R7 one-shot
    per_en = 0;
    exp_spacing = 0;
    settle(60);
    per = 19; mid = 0; dly = 1; dv = 0;
    base_s = strobes; base_v = sets;
    settle(80);
    chk(strobes == base_s, "R7", "no capture unarmed", strobes - base_s, 0);
    for (int r = 1; r <= 2; r++) begin
      oneshot_req = 1'b1;
      settle(1);
      oneshot_req = 1'b0;
      settle(100);
      chk(strobes - base_s == r, "R7", "one strobe per request", strobes - base_s, r);
      chk(sets - base_v == r, "R7", "one set per request", sets - base_v, r);
    end

    // R9 drop while busy
    chk(!overrun, "R9", "no false overrun", overrun, 0);
    per = 5; tpos = 2; mid = 0; dly = 0; dv = 0;
    exp_spacing = 3 * (per + 1);
    last_strobe = -1; last_match = -1;
    per_en = 1;
    settle(90);
    chk(overrun, "R9", "overrun set", overrun, 1);
    per_en = 0;
    settle(60);
    chk(overrun, "R9", "overrun sticky", overrun, 1);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R10 watchdog actual=%0d expected=%0d", 150000, 0);
    finish_run();
  end

endmodule